// File: doc/BRIEF.md
# Timed Output Compare Edge Generator

This peripheral drives one output pin at a precisely chosen instant. It watches a free-running 64-bit time counter that it receives as an input. When the counter equals a programmed compare value, the peripheral schedules an edge on the pin. The edge is a rise, a fall or a toggle, as software selects. Software reaches the block through a plain 32-bit register bus with address, write enable, write data and combinational read data.

The compare value is 64 bits wide and is written as two 32-bit words. The upper word is staged first, and the lower-word write commits both halves at once. That same write arms the comparator. A match fires only once, after which the comparator is disarmed until the next lower-word write. A compare value of zero is treated as invalid and never fires. The pin changes a fixed two counter cycles after the match, so software subtracts two from its target tick.

Top module: `timed_edge_gen`

## Requirements
- R1: After reset the pin is low, and reads of the control word and of both compare words return zero.
- R2: The control word at byte offset 0x00 keeps bit 0 (enable), bit 1 (direction, 0 means drive the pin) and bits 3:2 (edge code). A read of it returns those four bits, and all other bits read as zero.
- R3: A write to offset 0x14 only stages the upper compare word. A write to offset 0x10 commits the staged upper word together with the written lower word, and arms the comparator. Reads at 0x10 and 0x14 return the lower and upper words of the committed value. A staged upper word is never compared.
- R4: The clock edge that samples the time counter equal to the armed compare value is edge k. The pin takes its new value right after edge k+2, and never earlier or later.
- R5: Edge code 0 drives the pin high, code 1 drives it low, code 2 inverts it, and code 3 leaves it unchanged. The code in force when the match is sampled is the one that applies.
- R6: A committed compare value of zero never changes the pin, even while enabled and with the counter at zero.
- R7: A match fires once. With the counter held at the compare value, the pin changes only once until another write to offset 0x10 re-arms the comparator.
- R8: While the enable bit is clear, the pin never changes, and events already waiting in the delay stages are dropped.
- R9: With the direction bit set to 1, no match changes the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the time counter advances on it |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte address of the register access |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| timeNow | input | 64 | Current value of the free-running time counter |
| pinOut | output | 1 | Generated output pin |

## Verification
Two situations are hard to reach from the ports. In the first, a half-written compare value sits staged while the counter passes both the old and the new value. The bench parks a committed value, stages a different upper word, and sweeps the counter through both values. In the second, a match must not fire again while the counter stays put. The bench freezes the counter exactly on the compare value for many cycles, and then re-arms with the counter still frozen. Latency is checked in every counter sweep, cycle by cycle, over every edge code and three compare values, one of which makes the counter carry from the lower to the upper word.

// File: rtl/teg_pkg.sv
package teg_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE   = 2'd0,
    EDGE_FALL   = 2'd1,
    EDGE_TOGGLE = 2'd2,
    EDGE_NONE   = 2'd3
  } edgeSel_e;

  typedef struct packed {
    logic     enable;
    logic     dirIn;
    edgeSel_e edgeSel;
  } ctrlReg_t;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic     loadCmp;
    logic     armed;
    logic     outputOn;
    logic     flush;
    edgeSel_e edgeSel;
  } dpStrobe_t;

  typedef struct packed {
    logic     valid;
    edgeSel_e edgeSel;
  } evtStage_t;

  function automatic logic applyEdge(input edgeSel_e sel, input logic cur);
    case (sel)
      EDGE_RISE:   applyEdge = 1'b1;
      EDGE_FALL:   applyEdge = 1'b0;
      EDGE_TOGGLE: applyEdge = ~cur;
      default:     applyEdge = cur;
    endcase
  endfunction

endpackage

// File: rtl/teg_ctrl.sv
module teg_ctrl
  import teg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int TIME_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [TIME_W-1:0] cmpNow,
  input  logic              matchHit,
  output dpStrobe_t         strb,
  output logic [TIME_W-1:0] cmpLoadVal,
  output logic              armedQ,
  output logic              loadLo
);

  localparam logic [ADDR_W-1:0] OFS_CTRL   = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_CMP_LO = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_CMP_HI = ADDR_W'(8'h14);
  localparam int HI_W = TIME_W - DATA_W;

  ctrlReg_t          ctrlQ;
  logic [HI_W-1:0]   pendHiQ;
  logic              wrCtrl;
  logic              wrHi;

  assign wrCtrl = busWe && (busAddr == OFS_CTRL);
  assign wrHi   = busWe && (busAddr == OFS_CMP_HI);
  assign loadLo = busWe && (busAddr == OFS_CMP_LO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '{enable: 1'b0, dirIn: 1'b0, edgeSel: EDGE_RISE};
      pendHiQ <= '0;
      armedQ  <= 1'b0;
    end else begin
      if (wrCtrl) begin
        ctrlQ.enable  <= busWdata[0];
        ctrlQ.dirIn   <= busWdata[1];
        ctrlQ.edgeSel <= edgeSel_e'(busWdata[3:2]);
      end
      if (wrHi) pendHiQ <= busWdata[HI_W-1:0];
      if (loadLo)        armedQ <= 1'b1;
      else if (matchHit) armedQ <= 1'b0;
    end
  end

  assign cmpLoadVal = {pendHiQ, busWdata};

  always_comb begin
    strb.loadCmp  = loadLo;
    strb.armed    = armedQ;
    strb.outputOn = ctrlQ.enable & ~ctrlQ.dirIn;
    strb.flush    = ~ctrlQ.enable;
    strb.edgeSel  = ctrlQ.edgeSel;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFS_CTRL:   busRdata[3:0] = {ctrlQ.edgeSel, ctrlQ.dirIn, ctrlQ.enable};
      OFS_CMP_LO: busRdata = cmpNow[DATA_W-1:0];
      OFS_CMP_HI: busRdata = cmpNow[TIME_W-1:DATA_W];
      default:    busRdata = '0;
    endcase
  end

endmodule

// File: rtl/teg_datapath.sv
module teg_datapath
  import teg_pkg::*;
#(
  parameter int TIME_W    = 64,
  parameter int MATCH_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [TIME_W-1:0] cmpLoadVal,
  input  logic [TIME_W-1:0] timeNow,
  output logic [TIME_W-1:0] cmpQ,
  output logic              matchHit,
  output logic              pinOut
);

  evtStage_t pipeQ [MATCH_LAT];
  logic      pinQ;

  always_ff @(posedge clk) begin
    if (!rstN)             cmpQ <= '0;
    else if (strb.loadCmp) cmpQ <= cmpLoadVal;
  end

  assign matchHit = strb.armed && strb.outputOn && (|cmpQ) && (timeNow == cmpQ);

  for (genvar s = 0; s < MATCH_LAT; s++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN || strb.flush) begin
        pipeQ[s] <= '{valid: 1'b0, edgeSel: EDGE_RISE};
      end else if (s == 0) begin
        pipeQ[s] <= '{valid: matchHit, edgeSel: strb.edgeSel};
      end else begin
        pipeQ[s] <= pipeQ[(s == 0) ? 0 : s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pinQ <= 1'b0;
    else if (strb.outputOn && pipeQ[MATCH_LAT-1].valid)
      pinQ <= applyEdge(pipeQ[MATCH_LAT-1].edgeSel, pinQ);
  end

  assign pinOut = pinQ;

endmodule

// File: rtl/timed_edge_gen.sv
module timed_edge_gen
  import teg_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int MATCH_LAT = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWe,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [2*DATA_W-1:0]   timeNow,
  output logic                  pinOut
);

  localparam int TIME_W = 2 * DATA_W;

  dpStrobe_t         strb;
  logic [TIME_W-1:0] cmpLoadVal;
  logic [TIME_W-1:0] cmpQ;
  logic              matchHit;
  logic              armedQ;
  logic              loadLo;
  logic              outputOn;

  teg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIME_W(TIME_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .cmpNow(cmpQ), .matchHit(matchHit),
    .strb(strb), .cmpLoadVal(cmpLoadVal), .armedQ(armedQ), .loadLo(loadLo)
  );

  teg_datapath #(.TIME_W(TIME_W), .MATCH_LAT(MATCH_LAT)) uDp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .cmpLoadVal(cmpLoadVal), .timeNow(timeNow),
    .cmpQ(cmpQ), .matchHit(matchHit), .pinOut(pinOut)
  );

  assign outputOn = strb.outputOn;

endmodule

// File: rtl/teg_checker.sv
module teg_checker #(
  parameter int MATCH_LAT = 2
) (
  input logic clk,
  input logic rstN,
  input logic pinOut,
  input logic matchHit,
  input logic armedQ,
  input logic loadLo,
  input logic outputOn
);

  logic [MATCH_LAT:0] hitHist;

  always_ff @(posedge clk) begin
    if (!rstN) hitHist <= '0;
    else       hitHist <= {hitHist[MATCH_LAT-1:0], matchHit};
  end

  AST_PIN_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut != $past(pinOut)) |-> hitHist[MATCH_LAT]); // R4

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> (!armedQ || $past(loadLo))); // R7

  AST_ARM_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armedQ) |-> $past(loadLo)); // R3

  AST_STOP_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut != $past(pinOut)) |-> $past(outputOn)); // R8

endmodule

bind timed_edge_gen teg_checker #(.MATCH_LAT(MATCH_LAT)) uChk (
  .clk(clk), .rstN(rstN), .pinOut(pinOut), .matchHit(matchHit),
  .armedQ(armedQ), .loadLo(loadLo), .outputOn(outputOn)
);

// File: tb/tb_timed_edge_gen.sv
`timescale 1ns/1ps
module tb_timed_edge_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] timeNow = '0;
  logic        pinOut;

  int vectors = 0;
  int fails = 0;
  logic expPin = 1'b0;

  timed_edge_gen dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .timeNow(timeNow), .pinOut(pinOut)
  );

  always #5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    step();
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic armCmp(input logic [63:0] v);
    wr(5'h14, v[63:32]);
    wr(5'h10, v[31:0]);
  endtask

  // counter swept from cmp-4; pin expected new after edge k+2 (i >= 6)
  task automatic sweep(input string req, input logic [63:0] cmp, input logic fires,
                       input logic newVal);
    for (int i = 0; i < 8; i++) begin
      timeNow = cmp - 64'd4 + 64'(i);
      step();
      check(req, {63'd0, pinOut}, {63'd0, (fires && i >= 6) ? newVal : expPin});
    end
    if (fires) expPin = newVal;
    timeNow = '0;
  endtask

  function automatic logic edgeResult(input int code, input logic cur);
    case (code)
      0: edgeResult = 1'b1;
      1: edgeResult = 1'b0;
      2: edgeResult = ~cur;
      default: edgeResult = cur;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [63:0] cmps [3];
    cmps[0] = 64'h5;
    cmps[1] = 64'h0000_0001_0000_0002;
    cmps[2] = 64'hFFFF_FFFF_FFFF_FFF0;

    repeat (3) step();
    rstN = 1'b1;
    step();

    // R1 reset state
    check("R1 pin", {63'd0, pinOut}, 64'd0);
    rd(5'h00, r); check("R1 ctrl", {32'd0, r}, 64'd0);
    rd(5'h10, r); check("R1 cmpLo", {32'd0, r}, 64'd0);
    rd(5'h14, r); check("R1 cmpHi", {32'd0, r}, 64'd0);

    // R2 control layout and readback
    wr(5'h00, 32'hFFFF_FFF2);
    rd(5'h00, r); check("R2 ctrl F2", {32'd0, r}, 64'h2);
    wr(5'h00, 32'h0000_000D);
    rd(5'h00, r); check("R2 ctrl D", {32'd0, r}, 64'hD);

    // R4 R5 sweep over edge codes and compare values
    for (int rep = 0; rep < 2; rep++) begin
      for (int code = 0; code < 4; code++) begin
        for (int c = 0; c < 3; c++) begin
          wr(5'h00, {28'd0, 2'(code), 2'b01});
          armCmp(cmps[c]);
          rd(5'h10, r); check("R3 readLo", {32'd0, r}, {32'd0, cmps[c][31:0]});
          rd(5'h14, r); check("R3 readHi", {32'd0, r}, {32'd0, cmps[c][63:32]});
          sweep("R4 R5 edge", cmps[c], 1'b1, edgeResult(code, expPin));
        end
      end
    end

    // R3 staged upper word is not compared
    wr(5'h00, 32'h9);
    armCmp(64'h0000_0000_0000_0100);
    wr(5'h14, 32'h7);
    rd(5'h14, r); check("R3 hi staged", {32'd0, r}, 64'd0);
    sweep("R3 staged no fire", 64'h0000_0007_0000_0100, 1'b0, expPin);
    sweep("R3 old value fires", 64'h0000_0000_0000_0100, 1'b1, ~expPin);
    wr(5'h10, 32'h100);
    rd(5'h14, r); check("R3 hi commit", {32'd0, r}, 64'h7);
    sweep("R3 new value fires", 64'h0000_0007_0000_0100, 1'b1, ~expPin);

    // R7 one shot with counter frozen on the compare value
    armCmp(64'd50);
    timeNow = 64'd50;
    repeat (8) step();
    expPin = ~expPin;
    check("R7 once", {63'd0, pinOut}, {63'd0, expPin});
    wr(5'h10, 32'd50);
    repeat (5) step();
    expPin = ~expPin;
    check("R7 rearm", {63'd0, pinOut}, {63'd0, expPin});
    timeNow = '0;

    // R6 zero compare
    armCmp(64'd0);
    timeNow = 64'd0;
    repeat (6) step();
    check("R6 zero", {63'd0, pinOut}, {63'd0, expPin});

    // R8 disabled
    armCmp(64'd200);
    wr(5'h00, 32'h8);
    sweep("R8 disabled", 64'd200, 1'b0, expPin);

    // R8 in-flight event dropped by disable
    wr(5'h00, 32'h9);
    armCmp(64'd400);
    timeNow = 64'd400;
    busAddr = 5'h00; busWdata = 32'h8; busWe = 1'b1;
    step();
    busWe = 1'b0;
    timeNow = '0;
    repeat (4) step();
    check("R8 in-flight", {63'd0, pinOut}, {63'd0, expPin});

    // R9 direction input
    wr(5'h00, 32'hB);
    armCmp(64'd300);
    sweep("R9 dir", 64'd300, 1'b0, expPin);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule